// File: doc/BRIEF.md
# Data Address Translator with Fault Capture

This block turns the virtual address of a load or store into a physical address in one registered step. It chooses the access mode from the program counter's low bit and an alternate-mode request. It recognises malformed addresses and a kernel-only direct-mapped window. For every other address it asks an external page lookup through a combinational port and checks the returned read and write permissions for the chosen mode. It also rejects results that fall beyond the implemented physical range.

On a translation-class fault the block records three values. The first is the faulting virtual address. The second is a packed status word holding the instruction's opcode, its Ra register field and a set of cause flags. The third is a formatted page-table entry address built from a base register and the virtual page number. These capture registers hold their contents until the next such fault. The page storage and the miss handler sit outside the block.

Top module: `dxlate_unit`

## Requirements
- R1: Every cycle with `req_valid` high produces `rsp_valid` high on the next cycle. A cycle without a request gives `rsp_valid` low on the next cycle.
- R2: An address whose bits 63:48 are not all copies of bit 47 is malformed. It yields fault code 2 with cause bits bad-VA, access-violation and write (write only for stores). This check takes precedence over every other check.
- R3: A well-formed address with bits 47:41 equal to 0x7e, accessed while `cur_mode` is 0 (kernel), needs no page lookup and gives fault code 0. Its physical address is `req_va[39:0]` with bits 43:40 all set if bit 40 is 1, and all clear if bit 40 is 0.
- R4: A window address from R3 accessed while `cur_mode` is not 0 gives fault code 1, with cause access-violation plus write for stores. This holds even when the PC low bit is 1.
- R5: The effective mode is `cur_mode` when `req_pc_lsb` is 0. When `req_pc_lsb` is 1 it is `alt_mode` if `req_alt` is set, and 0 otherwise. Permission bit N of `tlb_rd_en` and `tlb_wr_en` belongs to mode N.
- R6: `tlb_vpn` is `req_va[47:13]`. A lookup hit with no fault gives the physical address `{tlb_ppn, req_va[12:0]}`. `rsp_paddr` is 0 whenever the fault code is not 0.
- R7: A lookup miss gives fault code 3, with cause miss plus write for stores.
- R8: A store with its write-enable bit clear gives fault code 2, cause write and access-violation, plus fault-on-write if `tlb_fow` is set. A store that is permitted but has `tlb_fow` set gives fault code 2, cause write and fault-on-write.
- R9: A load with its read-enable bit clear gives fault code 1, cause access-violation, plus fault-on-read if `tlb_for` is set. A permitted load with `tlb_for` set gives fault code 2, cause fault-on-read.
- R10: A translated address with any bit at position 44 or above set (`tlb_ppn[31]`) gives fault code 4 (machine check) and a zero address. The capture registers do not change.
- R11: On fault codes 1, 2 or 3 the capture registers load in the response cycle. `flt_va` takes the request address. `flt_stat` takes opcode at bits 16:11, Ra at 10:6, and causes at 5:0 (bit 0 write, 1 access-violation, 2 fault-on-read, 3 fault-on-write, 4 bad-VA, 5 miss). `flt_form` takes `req_ptbr | (vpn << 3)`.
- R12: Reset clears every output register. Without a code 1 to 3 fault, the capture registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | 1 for store, 0 for load |
| req_pc_lsb | input | 1 | Low bit of the program counter (privileged-code marker) |
| req_alt | input | 1 | Use the alternate mode when in privileged code |
| cur_mode | input | 2 | Current processor mode, 0 = kernel |
| alt_mode | input | 2 | Alternate mode |
| req_opcode | input | 6 | Opcode of the requesting instruction |
| req_ra | input | 5 | Ra field of the requesting instruction |
| req_ptbr | input | 64 | Page-table base for the formatted fault address |
| tlb_vpn | output | 35 | Virtual page number presented to the lookup |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_ppn | input | 32 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_for | input | 1 | Entry fault-on-read flag |
| tlb_fow | input | 1 | Entry fault-on-write flag |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 44 | Physical address |
| rsp_fault | output | 3 | 0 none, 1 access violation, 2 translation fault, 3 miss, 4 machine check |
| flt_va | output | 64 | Captured faulting address |
| flt_stat | output | 17 | Captured packed fault status |
| flt_form | output | 64 | Captured formatted page-table address |

## Verification
Random requests come from several address classes: low and high well-formed addresses, window addresses and malformed addresses. They are crossed with random modes, PC low bit, alternate flag, hit, permissions, fault-on flags and out-of-range page numbers. This separates the precedence between malformed, window, miss, permission and range checks. Directed cases cover each side of the bit-40 sign extension, privileged code with and without the alternate flag, and each fault-on flag with its enable both set and clear. A machine check that follows a captured fault shows whether the capture registers hold their values.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  localparam int NCAUSE  = 6;
  localparam int C_WR    = 0;
  localparam int C_ACV   = 1;
  localparam int C_FONR  = 2;
  localparam int C_FONW  = 3;
  localparam int C_BADVA = 4;
  localparam int C_MISS  = 5;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ACV   = 3'd1,
    FLT_TRANS = 3'd2,
    FLT_MISS  = 3'd3,
    FLT_MCHK  = 3'd4
  } fault_e;
endpackage

// File: rtl/dxl_mode_sel.sv
module dxl_mode_sel #(
  parameter int MODE_W = 2
) (
  input  logic              pal,
  input  logic              use_alt,
  input  logic [MODE_W-1:0] cur,
  input  logic [MODE_W-1:0] alt,
  output logic [MODE_W-1:0] eff
);
  always_comb begin
    if (!pal)        eff = cur;
    else if (use_alt) eff = alt;
    else              eff = '0;
  end
endmodule

// File: rtl/dxl_classify.sv
module dxl_classify #(
  parameter int VA_W     = 64,
  parameter int IMPL_VA  = 48,
  parameter int PA_W     = 44,
  parameter int SP_LO    = 41,
  parameter int SX_BIT   = 40,
  parameter logic [IMPL_VA-SP_LO-1:0] SP_TAG = 7'h7e
) (
  input  logic [VA_W-1:0] va,
  output logic            bad_va,
  output logic            is_super,
  output logic [PA_W-1:0] super_pa
);
  localparam int HI_W = VA_W - IMPL_VA + 1;

  logic [HI_W-1:0] hi;

  assign hi       = va[VA_W-1:IMPL_VA-1];
  assign bad_va   = !((&hi) || (~|hi));
  assign is_super = !bad_va && (va[IMPL_VA-1:SP_LO] == SP_TAG);

  always_comb begin
    super_pa = va[PA_W-1:0];
    if (va[SX_BIT]) super_pa[PA_W-1:SX_BIT] = '1;
    else            super_pa[PA_W-1:SX_BIT] = '0;
  end
endmodule

// File: rtl/dxl_resolve.sv
module dxl_resolve
  import dxl_pkg::*;
(
  input  logic              bad_va,
  input  logic              is_super,
  input  logic              kernel,
  input  logic              write,
  input  logic              hit,
  input  logic              rd_ok,
  input  logic              wr_ok,
  input  logic              fonr,
  input  logic              fonw,
  input  logic              pa_over,
  output fault_e            flt,
  output logic [NCAUSE-1:0] cause
);
  always_comb begin
    flt   = FLT_NONE;
    cause = '0;
    if (bad_va) begin
      flt           = FLT_TRANS;
      cause[C_WR]   = write;
      cause[C_ACV]  = 1'b1;
      cause[C_BADVA]= 1'b1;
    end else if (is_super) begin
      if (!kernel) begin
        flt          = FLT_ACV;
        cause[C_WR]  = write;
        cause[C_ACV] = 1'b1;
      end
    end else if (!hit) begin
      flt           = FLT_MISS;
      cause[C_WR]   = write;
      cause[C_MISS] = 1'b1;
    end else if (write && !wr_ok) begin
      flt           = FLT_TRANS;
      cause[C_WR]   = 1'b1;
      cause[C_ACV]  = 1'b1;
      cause[C_FONW] = fonw;
    end else if (write && fonw) begin
      flt           = FLT_TRANS;
      cause[C_WR]   = 1'b1;
      cause[C_FONW] = 1'b1;
    end else if (!write && !rd_ok) begin
      flt           = FLT_ACV;
      cause[C_ACV]  = 1'b1;
      cause[C_FONR] = fonr;
    end else if (!write && fonr) begin
      flt           = FLT_TRANS;
      cause[C_FONR] = 1'b1;
    end else if (pa_over) begin
      flt = FLT_MCHK;
    end
  end
endmodule

// File: rtl/dxl_fault_regs.sv
module dxl_fault_regs #(
  parameter int VA_W   = 64,
  parameter int STAT_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [VA_W-1:0]   va_in,
  input  logic [STAT_W-1:0] stat_in,
  input  logic [VA_W-1:0]   form_in,
  output logic [VA_W-1:0]   va_q,
  output logic [STAT_W-1:0] stat_q,
  output logic [VA_W-1:0]   form_q
);
  logic [VA_W-1:0]   va_d;
  logic [STAT_W-1:0] stat_d;
  logic [VA_W-1:0]   form_d;

  always_comb begin
    va_d   = va_q;
    stat_d = stat_q;
    form_d = form_q;
    if (cap_en) begin
      va_d   = va_in;
      stat_d = stat_in;
      form_d = form_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      stat_q <= '0;
      form_q <= '0;
    end else begin
      va_q   <= va_d;
      stat_q <= stat_d;
      form_q <= form_d;
    end
  end
endmodule

// File: rtl/dxlate_unit.sv
module dxlate_unit
  import dxl_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int IMPL_VA  = 48,
  parameter int PA_W     = 44,
  parameter int PG_SHIFT = 13,
  parameter int PPN_W    = 32,
  parameter int MODE_W   = 2,
  parameter int OPC_W    = 6,
  parameter int RA_W     = 5,
  parameter int SP_LO    = 41,
  parameter int SX_BIT   = 40,
  parameter logic [IMPL_VA-SP_LO-1:0] SP_TAG = 7'h7e,
  localparam int VPN_W   = IMPL_VA - PG_SHIFT,
  localparam int NMODE   = 1 << MODE_W,
  localparam int TPA_W   = PPN_W + PG_SHIFT,
  localparam int STAT_W  = OPC_W + RA_W + NCAUSE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  input  logic              req_pc_lsb,
  input  logic              req_alt,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  input  logic [OPC_W-1:0]  req_opcode,
  input  logic [RA_W-1:0]   req_ra,
  input  logic [VA_W-1:0]   req_ptbr,
  output logic [VPN_W-1:0]  tlb_vpn,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic [NMODE-1:0]  tlb_rd_en,
  input  logic [NMODE-1:0]  tlb_wr_en,
  input  logic              tlb_for,
  input  logic              tlb_fow,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [2:0]        rsp_fault,
  output logic [VA_W-1:0]   flt_va,
  output logic [STAT_W-1:0] flt_stat,
  output logic [VA_W-1:0]   flt_form
);
  logic [MODE_W-1:0] eff_mode;
  logic              bad_va, is_super;
  logic [PA_W-1:0]   super_pa;
  logic [TPA_W-1:0]  tpa;
  logic              pa_over;
  fault_e            flt;
  logic [NCAUSE-1:0] cause;
  logic              cap_en;
  logic [VA_W-1:0]   form_in;

  logic              rsp_valid_d;
  logic [PA_W-1:0]   rsp_paddr_d;
  logic [2:0]        rsp_fault_d;

  assign tlb_vpn = req_va[IMPL_VA-1:PG_SHIFT];

  dxl_mode_sel #(.MODE_W(MODE_W)) u_mode (
    .pal(req_pc_lsb), .use_alt(req_alt), .cur(cur_mode), .alt(alt_mode), .eff(eff_mode)
  );

  dxl_classify #(
    .VA_W(VA_W), .IMPL_VA(IMPL_VA), .PA_W(PA_W),
    .SP_LO(SP_LO), .SX_BIT(SX_BIT), .SP_TAG(SP_TAG)
  ) u_cls (
    .va(req_va), .bad_va(bad_va), .is_super(is_super), .super_pa(super_pa)
  );

  assign tpa     = {tlb_ppn, req_va[PG_SHIFT-1:0]};
  assign pa_over = |tpa[TPA_W-1:PA_W];

  dxl_resolve u_res (
    .bad_va(bad_va), .is_super(is_super), .kernel(cur_mode == '0),
    .write(req_write), .hit(tlb_hit),
    .rd_ok(tlb_rd_en[eff_mode]), .wr_ok(tlb_wr_en[eff_mode]),
    .fonr(tlb_for), .fonw(tlb_fow), .pa_over(pa_over),
    .flt(flt), .cause(cause)
  );

  assign cap_en  = req_valid && (flt == FLT_ACV || flt == FLT_TRANS || flt == FLT_MISS);
  assign form_in = req_ptbr | {{(VA_W-VPN_W-3){1'b0}}, tlb_vpn, 3'b000};

  dxl_fault_regs #(.VA_W(VA_W), .STAT_W(STAT_W)) u_freg (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .va_in(req_va), .stat_in({req_opcode, req_ra, cause}), .form_in(form_in),
    .va_q(flt_va), .stat_q(flt_stat), .form_q(flt_form)
  );

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_paddr_d = rsp_paddr;
    rsp_fault_d = rsp_fault;
    if (req_valid) begin
      rsp_fault_d = flt;
      if (flt != FLT_NONE) rsp_paddr_d = '0;
      else if (is_super)   rsp_paddr_d = super_pa;
      else                 rsp_paddr_d = tpa[PA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_paddr <= rsp_paddr_d;
      rsp_fault <= rsp_fault_d;
    end
  end
endmodule

// File: rtl/dxl_checker.sv
module dxl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [63:0] req_va,
  input logic [1:0]  cur_mode,
  input logic [5:0]  req_opcode,
  input logic [4:0]  req_ra,
  input logic        rsp_valid,
  input logic [43:0] rsp_paddr,
  input logic [2:0]  rsp_fault,
  input logic [63:0] flt_va,
  input logic [16:0] flt_stat,
  input logic [63:0] flt_form
);
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r3_window_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (&req_va[63:48]) && req_va[47:41] == 7'h7e && cur_mode == 2'd0)
    |=> (rsp_fault == 3'd0 && rsp_paddr[39:0] == $past(req_va[39:0])));

  a_r6_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> rsp_paddr == '0);

  a_r7_miss_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 3'd3) |-> (flt_stat[5] && !flt_stat[4]));

  a_r11_capture_fields: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((rsp_fault == 3'd0 || rsp_fault == 3'd4) ||
                   (flt_stat[16:6] == {$past(req_opcode), $past(req_ra)} &&
                    flt_va == $past(req_va))));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid || rsp_fault == 3'd0 || rsp_fault == 3'd4)
    |-> ($stable(flt_va) && $stable(flt_stat) && $stable(flt_form)));
endmodule

bind dxlate_unit dxl_checker u_chk (.*);

// File: tb/sim_dxlate_unit.sv
`timescale 1ns/1ps
module sim_dxlate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_pc_lsb, req_alt;
  logic [63:0] req_va, req_ptbr;
  logic [1:0]  cur_mode, alt_mode;
  logic [5:0]  req_opcode;
  logic [4:0]  req_ra;
  logic [34:0] tlb_vpn;
  logic        tlb_hit, tlb_for, tlb_fow;
  logic [31:0] tlb_ppn;
  logic [3:0]  tlb_rd_en, tlb_wr_en;
  logic        rsp_valid;
  logic [43:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic [63:0] flt_va, flt_form;
  logic [16:0] flt_stat;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [63:0] e_va = '0, e_form = '0;
  logic [16:0] e_stat = '0;

  always #10 clk = ~clk;

  dxlate_unit u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model(
      input logic [63:0] va, input bit wr, pcl, altf, input logic [1:0] cm, am,
      input bit hit, input logic [31:0] ppn, input logic [3:0] rd, wn, input bit fr, fw,
      output logic [2:0] f, output logic [43:0] pa, output logic [5:0] cz, output string tag);
    logic [1:0] md;
    bit canon, win;
    md    = pcl ? (altf ? am : 2'd0) : cm;
    canon = (va[63:47] == '0) || (va[63:47] == '1);
    win   = canon && va[47:41] == 7'h7e;
    f = 3'd0; pa = '0; cz = '0; tag = "R6";
    if (!canon) begin
      f = 3'd2; cz = {1'b0, 1'b1, 2'b00, 1'b1, wr}; tag = "R2";
    end else if (win) begin
      if (cm != 2'd0) begin f = 3'd1; cz = {4'b0000, 1'b1, wr}; tag = "R4"; end
      else begin
        tag = "R3";
        pa = va[40] ? {4'hf, va[39:0]} : {4'h0, va[39:0]};
      end
    end else if (!hit) begin
      f = 3'd3; cz = {1'b1, 4'b0000, wr}; tag = "R7";
    end else if (wr) begin
      tag = "R8";
      if (!wn[md])  begin f = 3'd2; cz = {2'b00, fw, 1'b0, 1'b1, 1'b1}; end
      else if (fw)  begin f = 3'd2; cz = 6'b001001; end
    end else begin
      tag = "R9";
      if (!rd[md])  begin f = 3'd1; cz = {3'b000, fr, 1'b1, 1'b0}; end
      else if (fr)  begin f = 3'd2; cz = 6'b000100; end
    end
    if (f == 3'd0 && !win) begin
      if (ppn[31]) begin f = 3'd4; tag = "R10"; end
      else pa = {ppn[30:0], va[12:0]};
    end
    if (pcl && f inside {3'd1, 3'd2} && (tag == "R8" || tag == "R9")) tag = {tag, "/R5"};
  endfunction

  task automatic run(input logic [63:0] va, input bit wr, pcl, altf, input logic [1:0] cm, am,
                     input bit hit, input logic [31:0] ppn, input logic [3:0] rd, wn, input bit fr, fw);
    logic [2:0] f; logic [43:0] pa; logic [5:0] cz; string tag;
    logic [5:0] opc; logic [4:0] ra; logic [63:0] ptbr;
    opc = 6'($urandom); ra = 5'($urandom); ptbr = {$urandom, $urandom};
    model(va, wr, pcl, altf, cm, am, hit, ppn, rd, wn, fr, fw, f, pa, cz, tag);
    req_valid = 1; req_va = va; req_write = wr; req_pc_lsb = pcl; req_alt = altf;
    cur_mode = cm; alt_mode = am; req_opcode = opc; req_ra = ra; req_ptbr = ptbr;
    tlb_hit = hit; tlb_ppn = ppn; tlb_rd_en = rd; tlb_wr_en = wn; tlb_for = fr; tlb_fow = fw;
    #1 chk("R6 vpn", 64'(tlb_vpn), 64'(va[47:13]));
    @(negedge clk);
    req_valid = 0;
    if (f inside {3'd1, 3'd2, 3'd3}) begin
      e_va = va; e_stat = {opc, ra, cz}; e_form = ptbr | {26'd0, va[47:13], 3'b000};
    end
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd1);
    chk({tag, " fault"}, 64'(rsp_fault), 64'(f));
    chk({tag, " paddr"}, 64'(rsp_paddr), 64'(pa));
    chk((f inside {3'd1, 3'd2, 3'd3}) ? "R11 va" : "R12 va hold", flt_va, e_va);
    chk((f inside {3'd1, 3'd2, 3'd3}) ? "R11 stat" : "R12 stat hold", 64'(flt_stat), 64'(e_stat));
    chk((f inside {3'd1, 3'd2, 3'd3}) ? "R11 form" : "R12 form hold", flt_form, e_form);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; req_valid = 0; req_va = '0; req_write = 0; req_pc_lsb = 0; req_alt = 0;
    cur_mode = '0; alt_mode = '0; req_opcode = '0; req_ra = '0; req_ptbr = '0;
    tlb_hit = 0; tlb_ppn = '0; tlb_rd_en = '0; tlb_wr_en = '0; tlb_for = 0; tlb_fow = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset valid", 64'(rsp_valid), 0);
    chk("R12 reset paddr", 64'(rsp_paddr), 0);
    chk("R12 reset stat", 64'(flt_stat), 0);
    chk("R12 reset va", flt_va, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle", 64'(rsp_valid), 0);

    // R3 window, both sides of the bit-40 extension
    run(64'hFFFF_FD12_3456_789A, 0, 0, 0, 2'd0, 2'd0, 0, '0, '0, '0, 0, 0);
    run(64'hFFFF_FC12_3456_789A, 1, 0, 0, 2'd0, 2'd0, 0, '0, '0, '0, 0, 0);
    // R4 window from user mode, privileged PC still faults
    run(64'hFFFF_FC00_0000_1000, 1, 1, 0, 2'd3, 2'd0, 1, 32'h10, '1, '1, 0, 0);
    // R2 malformed
    run(64'h0001_0000_0000_0000, 1, 0, 0, 2'd0, 2'd0, 1, 32'h10, '1, '1, 0, 0);
    // R5 privileged code: kernel without alt, alt mode with alt
    run(64'h0000_0000_0040_2000, 0, 1, 0, 2'd3, 2'd2, 1, 32'h55, 4'b0001, 4'b0001, 0, 0);
    run(64'h0000_0000_0040_2000, 0, 1, 1, 2'd0, 2'd2, 1, 32'h55, 4'b0001, 4'b0001, 0, 0);
    // R7 store miss
    run(64'h0000_1234_5678_9ABC, 1, 0, 0, 2'd1, 2'd0, 0, '0, '1, '1, 0, 0);
    // R8 fault-on-write with and without enable
    run(64'h0000_0000_0000_4000, 1, 0, 0, 2'd1, 2'd0, 1, 32'h7, 4'b1111, 4'b1111, 0, 1);
    run(64'h0000_0000_0000_4000, 1, 0, 0, 2'd1, 2'd0, 1, 32'h7, 4'b1111, 4'b1101, 0, 1);
    // R9 fault-on-read with and without enable
    run(64'h0000_0000_0000_6000, 0, 0, 0, 2'd2, 2'd0, 1, 32'h9, 4'b1111, 4'b0000, 1, 0);
    run(64'h0000_0000_0000_6000, 0, 0, 0, 2'd2, 2'd0, 1, 32'h9, 4'b1011, 4'b0000, 1, 0);
    // R10 machine check after a capture: registers must hold
    run(64'h0000_0000_0000_8123, 0, 0, 0, 2'd0, 2'd0, 1, 32'h8000_0001, '1, '1, 0, 0);
    // R6 clean hit
    run(64'hFFFF_8000_0000_1FFF, 1, 0, 0, 2'd0, 2'd0, 1, 32'h7FFF_FFFF, '1, '1, 0, 0);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] va;
      int k;
      k  = int'($urandom % 5);
      va = {$urandom, $urandom};
      case (k)
        0: va[63:47] = '0;
        1: begin va[63:47] = '1; if (va[46:41] == 6'h3e) va[41] = 1'b1; end
        2: begin va[63:42] = '1; va[41] = 1'b0; end
        3: begin va[63:47] = '0; va[50] = 1'b1; end
        default: va[63:47] = ($urandom % 2) ? '1 : '0;
      endcase
      run(va, bit'($urandom), bit'($urandom), bit'($urandom), 2'($urandom), 2'($urandom),
          ($urandom % 8) != 0, {($urandom % 8) == 0, 31'($urandom)},
          4'($urandom), 4'($urandom), bit'($urandom), bit'($urandom));
      if (($urandom % 6) == 0) begin
        @(negedge clk);
        chk("R1 gap", 64'(rsp_valid), 0);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule